// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Commit Controller

This block sits behind an I2C target front end and receives already-decoded transaction events. The events are start, repeated start, stop, a register address byte and data bytes. It holds two copies of a small register set. The live copy drives the potentiometer wiper positions and the two amplifier gain selections. The backing copy stands in for nonvolatile memory.

An accepted data byte changes the live copy at once and marks the register as pending. A stop then programs every pending register into the backing copy and starts a program cycle, which holds a busy flag for a fixed number of clock cycles. A repeated start or a new start drops the pending marks instead, so only the live value changes. A write-protect input, pulled high at board level, blocks all writes while it is high. Reads of the live copy are always allowed.

A warm reset (`rst_n`) reloads the live copy from the backing copy, which models a power cycle. A power-on reset (`por_n`) loads factory values into both copies, which models a blank memory.

Top module: `nvshadow_ctrl`

## Requirements
- R1: After power-on reset, both wiper registers read 20h, the gain register (address FBh) reads 11h, both gain outputs are 0 (gain 1), and `prog_busy` and `data_ack` are low. A warm reset reloads every live register from the backing copy.
- R2: A data byte sent to a mapped address is accepted when protection is off and no program cycle is running. `data_ack` goes high in the cycle after the data event, and the new value is visible on the outputs and on `rd_data` in that same cycle.
- R3: A stop that follows accepted writes copies the written registers into the backing copy. A warm reset afterwards restores those values.
- R4: A repeated start or start that arrives before the stop discards the pending commit. No program cycle starts, and a warm reset restores the older backing values.
- R5: A committing stop holds `prog_busy` high for exactly PROG_CYCLES cycles, starting in the cycle after the stop. A stop with no accepted write since the last start does not raise `prog_busy`.
- R6: Data bytes that arrive while `prog_busy` is high are not acknowledged and leave the live registers unchanged.
- R7: The gain register is at address FBh. Bits 6:4 drive `gain_amp1` and bits 2:0 drive `gain_amp0`. A field of 1XX gives code 2 (gain 4), 01X gives code 1 (gain 2), and 00X gives code 0 (gain 1).
- R8: Reserved bits are stored as zero. These are bits 7 and 3 of the gain register, and the bits above POT_BITS (bits 7:6 with default parameters) in a wiper register.
- R9: While `wp_hi` is high, data bytes are not acknowledged. The live and backing copies stay unchanged, and no program cycle starts.
- R10: `rd_data` returns the live value of any mapped register, whether or not write protection is active.
- R11: Data bytes sent to an unmapped address are not acknowledged and do not start a program cycle. Unmapped reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; loads factory values into both copies |
| rst_n | input | 1 | Warm reset, active low, synchronous; reloads the live copy from the backing copy |
| ev_start | input | 1 | Start condition event (one-cycle pulse) |
| ev_rstart | input | 1 | Repeated start event (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition event (one-cycle pulse) |
| ev_addr_vld | input | 1 | Register address byte valid |
| ev_addr | input | 8 | Register address byte |
| ev_data_vld | input | 1 | Data byte valid |
| ev_data | input | 8 | Data byte |
| wp_hi | input | 1 | Write protect; writes are accepted only while low |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Live value at `rd_addr`, combinational |
| data_ack | output | 1 | Data byte accepted (one cycle after the data event) |
| prog_busy | output | 1 | Backing-store program cycle running |
| pot_pos | output | NUM_POT*POT_BITS | Wiper positions, wiper 0 in the low bits |
| gain_amp0 | output | 2 | Amplifier 0 gain code |
| gain_amp1 | output | 2 | Amplifier 1 gain code |

## Verification
Every result that follows a data event is registered once. The acknowledge, the outputs and `rd_data` are therefore due in the cycle right after the event. The bench drives each event for one cycle starting at a falling edge and samples at the next falling edge. The busy flag begins in the cycle after the stop, and the bench counts the falling edges at which it is high, expecting exactly PROG_CYCLES. Backing-copy contents cannot be read directly, so the bench observes them by pulsing the warm reset and reading the reloaded live values.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        GAIN_X1 = 2'd0,
        GAIN_X2 = 2'd1,
        GAIN_X4 = 2'd2
    } gain_e;

    // Field priority: bit 2 wins over bit 1; bit 0 is ignored.
    function automatic gain_e gain_of(input logic [2:0] fld);
        gain_e g;
        casez (fld)
            3'b1??:  g = GAIN_X4;
            3'b01?:  g = GAIN_X2;
            default: g = GAIN_X1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/nvs_gain_decode.sv
module nvs_gain_decode
    import nvs_pkg::*;
(
    input  logic [3:0] nib,
    output logic [1:0] code
);
    gain_e g_d;

    always_comb begin
        g_d  = gain_of(nib[2:0]);
        code = g_d;
    end
endmodule

// File: rtl/nvs_prog_timer.sv
module nvs_prog_timer #(
    parameter int CYCLES = 5_000_000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (!por_n || !rst_n) begin
            d.cnt = '0;
        end else if (start) begin
            d.cnt = CW'(CYCLES);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign busy = (q.cnt != '0);

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        start |-> !busy);

    // R5
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/nvs_reg_bank.sv
module nvs_reg_bank #(
    parameter int NREG = 3,
    parameter logic [NREG-1:0][7:0] FACTORY = '0,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [7:0]               wr_val,
    input  logic                     commit,
    input  logic                     cancel,
    output logic [NREG-1:0][7:0]     live,
    output logic                     pending_any
);
    typedef struct packed {
        logic [NREG-1:0][7:0] live;
        logic [NREG-1:0][7:0] nv;
        logic [NREG-1:0]      pend;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (!por_n) begin
            d.live = FACTORY;
            d.nv   = FACTORY;
            d.pend = '0;
        end else if (!rst_n) begin
            d.live = q.nv;
            d.pend = '0;
        end else begin
            if (cancel) begin
                d.pend = '0;
            end
            if (commit) begin
                for (int i = 0; i < NREG; i++) begin
                    if (q.pend[i]) begin
                        d.nv[i] = q.live[i];
                    end
                end
                d.pend = '0;
            end
            if (wr_en) begin
                d.live[wr_idx] = wr_val;
                d.pend[wr_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign live        = q.live;
    assign pending_any = |q.pend;

    // R3
    nv_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ($past(por_n) && $past(rst_n) && !$past(commit)) |-> $stable(q.nv));

    // R9
    live_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ($past(por_n) && $past(rst_n) && !$past(wr_en)) |-> $stable(q.live));
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl #(
    parameter int          NUM_POT      = 2,
    parameter int          POT_BITS     = 6,
    parameter logic [7:0]  POT_BASE     = 8'hF8,
    parameter logic [7:0]  GAIN_ADDR    = 8'hFB,
    parameter logic [7:0]  POT_FACTORY  = 8'h20,
    parameter logic [7:0]  GAIN_FACTORY = 8'h11,
    parameter int          PROG_CYCLES  = 5_000_000
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         rst_n,
    input  logic                         ev_start,
    input  logic                         ev_rstart,
    input  logic                         ev_stop,
    input  logic                         ev_addr_vld,
    input  logic [7:0]                   ev_addr,
    input  logic                         ev_data_vld,
    input  logic [7:0]                   ev_data,
    input  logic                         wp_hi,
    input  logic [7:0]                   rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         data_ack,
    output logic                         prog_busy,
    output logic [NUM_POT*POT_BITS-1:0]  pot_pos,
    output logic [1:0]                   gain_amp0,
    output logic [1:0]                   gain_amp1
);
    localparam int NREG = NUM_POT + 1;
    localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0] POT_MASK  = 8'((1 << POT_BITS) - 1);
    localparam logic [7:0] GAIN_MASK = 8'h77;

    function automatic logic [NREG-1:0][7:0] factory_set();
        logic [NREG-1:0][7:0] f;
        for (int i = 0; i < NUM_POT; i++) begin
            f[i] = POT_FACTORY & POT_MASK;
        end
        f[NUM_POT] = GAIN_FACTORY & GAIN_MASK;
        return f;
    endfunction

    // MSB is the hit flag, low bits the register index.
    function automatic logic [IW:0] map_addr(input logic [7:0] a);
        logic [IW:0] r;
        r = '0;
        for (int i = 0; i < NUM_POT; i++) begin
            if (a == 8'(POT_BASE + 8'(i))) begin
                r = {1'b1, IW'(i)};
            end
        end
        if (a == GAIN_ADDR) begin
            r = {1'b1, IW'(NUM_POT)};
        end
        return r;
    endfunction

    typedef struct packed {
        logic [7:0] ptr;
        logic       ptr_vld;
        logic       ack;
    } ctl_t;

    ctl_t q, d;

    logic [NREG-1:0][7:0] live;
    logic                 pending_any;
    logic                 busy;
    logic [IW:0]          wmap;
    logic [IW:0]          rmap;
    logic                 wr_acc;
    logic [7:0]           wr_val;
    logic                 commit;
    logic                 cancel;
    logic                 run;

    always_comb begin
        run    = por_n && rst_n;
        wmap   = map_addr(q.ptr);
        wr_acc = run && ev_data_vld && q.ptr_vld && wmap[IW] && !wp_hi && !busy;
        if (wmap[IW-1:0] == IW'(NUM_POT)) begin
            wr_val = ev_data & GAIN_MASK;
        end else begin
            wr_val = ev_data & POT_MASK;
        end
        commit = run && ev_stop && pending_any && !busy;
        cancel = run && (ev_start || ev_rstart);

        d = q;
        if (!run) begin
            d = '0;
        end else begin
            d.ack = wr_acc;
            if (ev_start || ev_rstart || ev_stop) begin
                d.ptr_vld = 1'b0;
            end
            if (ev_addr_vld) begin
                d.ptr     = ev_addr;
                d.ptr_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    nvs_reg_bank #(
        .NREG    (NREG),
        .FACTORY (factory_set())
    ) u_bank (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .wr_en       (wr_acc),
        .wr_idx      (wmap[IW-1:0]),
        .wr_val      (wr_val),
        .commit      (commit),
        .cancel      (cancel),
        .live        (live),
        .pending_any (pending_any)
    );

    nvs_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .por_n (por_n),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    generate
        for (genvar g = 0; g < NUM_POT; g++) begin : g_pot
            assign pot_pos[g*POT_BITS +: POT_BITS] = live[g][POT_BITS-1:0];
        end
    endgenerate

    nvs_gain_decode u_gd0 (.nib(live[NUM_POT][3:0]), .code(gain_amp0));
    nvs_gain_decode u_gd1 (.nib(live[NUM_POT][7:4]), .code(gain_amp1));

    always_comb begin
        rmap    = map_addr(rd_addr);
        rd_data = rmap[IW] ? live[rmap[IW-1:0]] : 8'h00;
    end

    assign data_ack  = q.ack;
    assign prog_busy = busy;

    // R2 R6 R9
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        data_ack |-> $past(ev_data_vld && !wp_hi && !busy));

    // R8
    gain_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (live[NUM_POT][7] == 1'b0) && (live[NUM_POT][3] == 1'b0));

    // R9
    wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ($past(wp_hi) && $past(ev_data_vld)) |-> !data_ack);
endmodule

// File: tb/sim_nvshadow_ctrl.sv
`timescale 1ns/1ps
module sim_nvshadow_ctrl;
    localparam int P = 37;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr_vld = 0, ev_data_vld = 0;
    logic [7:0] ev_addr = 0, ev_data = 0, rd_addr = 0;
    logic wp_hi = 1'b0;
    logic [7:0] rd_data;
    logic data_ack, prog_busy;
    logic [11:0] pot_pos;
    logic [1:0] gain_amp0, gain_amp1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    nvshadow_ctrl #(.PROG_CYCLES(P)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
        .ev_addr_vld(ev_addr_vld), .ev_addr(ev_addr),
        .ev_data_vld(ev_data_vld), .ev_data(ev_data),
        .wp_hi(wp_hi), .rd_addr(rd_addr), .rd_data(rd_data),
        .data_ack(data_ack), .prog_busy(prog_busy), .pot_pos(pot_pos),
        .gain_amp0(gain_amp0), .gain_amp1(gain_amp1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int nib);
        int f = nib % 8;
        return (f >= 4) ? 2 : ((f >= 2) ? 1 : 0);
    endfunction

    task automatic do_start();
        ev_start = 1; @(negedge clk); ev_start = 0;
    endtask
    task automatic do_rstart();
        ev_rstart = 1; @(negedge clk); ev_rstart = 0;
    endtask
    task automatic do_stop();
        ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask
    task automatic do_addr(input logic [7:0] a);
        ev_addr = a; ev_addr_vld = 1; @(negedge clk); ev_addr_vld = 0;
    endtask
    task automatic do_data(input logic [7:0] v, output logic ack);
        ev_data = v; ev_data_vld = 1; @(negedge clk); ev_data_vld = 0;
        ack = data_ack;
    endtask
    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask
    task automatic warm_reset();
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    endtask
    task automatic wait_idle();
        while (prog_busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int n;

        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(8'hF8, v); chk(v == 8'h20, "R1 pot0", v, 8'h20);
        rd(8'hF9, v); chk(v == 8'h20, "R1 pot1", v, 8'h20);
        rd(8'hFB, v); chk(v == 8'h11, "R1 gain reg", v, 8'h11);
        chk(gain_amp0 == 0 && gain_amp1 == 0, "R1 gains", {gain_amp1, gain_amp0}, 0);
        chk(!prog_busy && !data_ack, "R1 busy/ack", {prog_busy, data_ack}, 0);

        // R7 R8 R2 R4: full gain sweep, each write ended by repeated start
        for (int g = 0; g < 256; g++) begin
            do_start(); do_addr(8'hFB); do_data(8'(g), ack);
            chk(ack, "R2 gain ack", ack, 1);
            chk(gain_amp0 == 2'(exp_code(g % 16)), "R7 amp0", gain_amp0, exp_code(g % 16));
            chk(gain_amp1 == 2'(exp_code(g / 16)), "R7 amp1", gain_amp1, exp_code(g / 16));
            rd(8'hFB, v); chk(v == 8'(g & 8'h77), "R8 gain reserved", v, g & 8'h77);
            do_rstart();
            chk(!prog_busy, "R4 no program after rstart", prog_busy, 0);
        end

        // R8 R2: wiper 0 sweep
        for (int p = 0; p < 256; p++) begin
            do_start(); do_addr(8'hF8); do_data(8'(p), ack);
            chk(ack && pot_pos[5:0] == 6'(p % 64), "R2 pot0 live", pot_pos[5:0], p % 64);
            rd(8'hF8, v); chk(v == 8'(p % 64), "R8 pot reserved", v, p % 64);
            do_start();
        end

        // R4: backing copy untouched by cancelled writes
        warm_reset();
        rd(8'hFB, v); chk(v == 8'h11, "R4 gain restored", v, 8'h11);
        rd(8'hF8, v); chk(v == 8'h20, "R4 pot0 restored", v, 8'h20);

        // R5 R3: committed write, exact busy length
        do_start(); do_addr(8'hF9); do_data(8'h2A, ack); do_stop();
        n = 0;
        while (prog_busy) begin n++; @(negedge clk); end
        chk(n == P, "R5 busy length", n, P);
        warm_reset();
        rd(8'hF9, v); chk(v == 8'h2A, "R3 pot1 committed", v, 8'h2A);

        // R6: write during program cycle
        do_start(); do_addr(8'hF8); do_data(8'h11, ack); do_stop();
        chk(prog_busy, "R5 busy after stop", prog_busy, 1);
        do_start(); do_addr(8'hF9); do_data(8'h05, ack);
        chk(!ack, "R6 no ack while busy", ack, 0);
        rd(8'hF9, v); chk(v == 8'h2A, "R6 live unchanged", v, 8'h2A);
        do_stop(); wait_idle();

        // R5: stop with no write
        do_start(); do_addr(8'hF8); do_stop();
        chk(!prog_busy, "R5 no program without write", prog_busy, 0);

        // R9 R10: write protection
        wp_hi = 1;
        do_start(); do_addr(8'hFB); do_data(8'h44, ack); do_stop();
        chk(!ack, "R9 no ack protected", ack, 0);
        chk(!prog_busy, "R9 no program protected", prog_busy, 0);
        rd(8'hFB, v); chk(v == 8'h11, "R9 live unchanged", v, 8'h11);
        rd(8'hF9, v); chk(v == 8'h2A, "R10 read while protected", v, 8'h2A);
        warm_reset();
        rd(8'hFB, v); chk(v == 8'h11, "R9 backing unchanged", v, 8'h11);
        wp_hi = 0;

        // R11: unmapped address
        do_start(); do_addr(8'h10); do_data(8'h55, ack); do_stop();
        chk(!ack, "R11 no ack unmapped", ack, 0);
        chk(!prog_busy, "R11 no program", prog_busy, 0);
        rd(8'h10, v); chk(v == 8'h00, "R11 unmapped read", v, 0);

        // R3 R7: commit gain, reload, decode
        do_start(); do_addr(8'hFB); do_data(8'h42, ack); do_stop(); wait_idle();
        warm_reset();
        chk(gain_amp1 == 2'd2 && gain_amp0 == 2'd1, "R7 committed gains",
            {gain_amp1, gain_amp0}, 4'h9);
        rd(8'hF8, v); chk(v == 8'h11, "R3 pot0 committed", v, 8'h11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule